// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter assembled from identical 4-bit slices. Each slice has its own clear, load and count logic and a combinational carry-out. The slices are chained so that each one counts only when every slice below it holds all ones. A counter of any multiple of four bits is therefore a single register stage wide, with no ripple through the flops.

Two count enables play different roles. The parallel enable is shared by all slices and only gates counting. The carry enable feeds the lowest slice's carry input, so it gates counting and the terminal-count output as well. Several of these counters can then be chained in turn, with the parallel enable kept common across them.

The controls are an active-low synchronous clear and an active-low synchronous parallel load. At each rising edge the clear wins over the load, the load wins over counting, and counting wins over holding. A separate asynchronous active-low reset puts the register at zero at power-up. Its release is synchronised to the clock, and it is kept apart from the functional clear.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes 0 on that edge, whatever `ld_n`, `en_par`, `en_carry` and `din` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `q` takes the value of `din` on that edge, whatever the enables are. Slice k takes `din[4k+3:4k]`.
- R3: When `clr_n`, `ld_n`, `en_par` and `en_carry` are all 1 at a rising edge, `q` increases by one modulo 2^W. The all-ones value wraps to 0.
- R4: When `clr_n` and `ld_n` are 1 and either `en_par` or `en_carry` is 0 at a rising edge, `q` keeps its value.
- R5: `tc` is 1 exactly when `en_carry` is 1 and every bit of `q` is 1. It does not depend on `en_par` and follows `en_carry` within the same cycle.
- R6: Slice k counts on an edge only when all bits of the slices below it are 1 and both enables are high. This gives a plain binary count across slice boundaries.
- R7: While `rst_n` is 0, `q` is 0. After `rst_n` rises, the register stays in reset for two more rising edges, and `q` then remains 0 until a load or a count occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, common to all slices |
| en_carry | input | 1 | Carry count enable into the lowest slice; also gates `tc` |
| din | input | W | Parallel load value |
| q | output | W | Counter value |
| tc | output | 1 | Terminal count: `en_carry` AND all bits of `q` |

## Verification
`q` is due one rising edge after the controls are applied. The bench drives the inputs at the falling edge, advances its own model at the next rising edge and compares `q` one time unit later. `tc` is combinational, so it is compared against the model state shortly after the inputs change, before the next rising edge. The reset release takes two extra edges, so the bench waits four edges before it starts its model. Stimulus mixes a full wrap of the 12-bit count, directed priority cases and seeded random controls.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Priority: clear, load, count, hold
  function automatic op_e pick_op(input logic clr_n, input logic ld_n,
                                  input logic en_p, input logic en_t);
    op_e r;
    if (!clr_n)            r = OP_CLEAR;
    else if (!ld_n)        r = OP_LOAD;
    else if (en_p && en_t) r = OP_COUNT;
    else                   r = OP_HOLD;
    return r;
  endfunction

endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_q_n = pipe_q[DEPTH-1];
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rst_q_n,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               rco
);
  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  op_e                op;
  logic [SLICE_W-1:0] cnt_q;
  logic [SLICE_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    op = pick_op(clr_n, ld_n, en_p, en_t);
  end

  // Next-state process
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = d;
      OP_COUNT: cnt_d = cnt_q + ONE;
      default:  cnt_en = 1'b0;
    endcase
  end

  // Register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q   = cnt_q;
  assign rco = en_t & (&cnt_q);
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int STAGES  = 3,
  parameter int SLICE_W = 4,
  parameter int SYNC_DEPTH = 2,
  localparam int W = STAGES * SLICE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_par,
  input  logic         en_carry,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  logic              rst_q_n;
  logic [STAGES:0]   carry_chain;

  ctr_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign carry_chain[0] = en_carry;

  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    ctr_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .clr_n   (clr_n),
      .ld_n    (ld_n),
      .en_p    (en_par),
      .en_t    (carry_chain[k]),
      .d       (din[k*SLICE_W +: SLICE_W]),
      .q       (q[k*SLICE_W +: SLICE_W]),
      .rco     (carry_chain[k+1])
    );
  end

  assign tc = carry_chain[STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_q_n,
  input logic         clr_n,
  input logic         ld_n,
  input logic         en_par,
  input logic         en_carry,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_n |=> q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && !ld_n) |=> q == $past(din));

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && ld_n && en_par && en_carry) |=> q == $past(q) + ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && ld_n && !(en_par && en_carry)) |=> $stable(q));

  p_tc_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    tc == (en_carry && (&q)));

  // R6: the top bit only moves on a count when all lower bits were ones
  p_cascade_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && ld_n && !(&q[W-2:0])) |=> q[W-1] == $past(q[W-1]));

  p_reset_r7: assert property (@(posedge clk)
    !rst_q_n |-> q == '0);

  // R7: the asynchronous reset input forces the internal reset low
  always_comb begin
    if (!rst_n) a_rst_r7: assert (!rst_q_n || $time == 0);
  end
endmodule

bind casc_counter casc_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_q_n  (rst_q_n),
  .clr_n    (clr_n),
  .ld_n     (ld_n),
  .en_par   (en_par),
  .en_carry (en_carry),
  .din      (din),
  .q        (q),
  .tc       (tc)
);

// File: tb/casc_counter_bench.sv
module casc_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 3;
  localparam int W = STAGES * 4;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr_n, ld_n, en_par, en_carry;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         tc;

  int           checks = 0;
  int           failures = 0;
  logic [W-1:0] exp_q;

  casc_counter #(.STAGES(STAGES)) u_casc_counter (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n),
    .en_par(en_par), .en_carry(en_carry), .din(din), .q(q), .tc(tc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
      input logic c, input logic l, input logic ep, input logic et,
      input logic [W-1:0] d);
    if (!c)            return '0;
    else if (!l)       return d;
    else if (ep && et) return cur + W'(1);
    else               return cur;
  endfunction

  function automatic logic model_tc(input logic [W-1:0] cur, input logic et);
    return et && (cur == ALL1);
  endfunction

  task automatic chk_q(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s q actual=%h expected=%h", req, q, exp);
    end
  endtask

  task automatic chk_tc(input string req, input logic exp);
    checks++;
    if (tc !== exp) begin
      failures++;
      $display("FAIL %s tc actual=%b expected=%b", req, tc, exp);
    end
  endtask

  // Apply at falling edge, check tc before the edge, q after it
  task automatic step(input string req, input logic c, input logic l,
                      input logic ep, input logic et, input logic [W-1:0] d);
    @(negedge clk);
    clr_n = c; ld_n = l; en_par = ep; en_carry = et; din = d;
    #1;
    chk_tc("R5", model_tc(exp_q, et));
    @(posedge clk);
    exp_q = model_next(exp_q, c, l, ep, et, d);
    #1;
    chk_q(req, exp_q);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; clr_n = 1'b1; ld_n = 1'b1; en_par = 1'b1; en_carry = 1'b1;
    din = '0;
    exp_q = '0;
    repeat (3) @(posedge clk);
    #1;
    chk_q("R7", '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: two edges of synchronised release, then hold with enables off
    en_par = 1'b0; en_carry = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk_q("R7", '0);

    // R2: load with both enables low, per-slice data
    step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 12'hA5C);
    // R4: hold with either enable low
    step("R4", 1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    step("R4", 1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
    // R1: clear wins over load
    step("R1", 1'b0, 1'b0, 1'b1, 1'b1, 12'hFFF);
    // R2: load wins over count
    step("R2", 1'b1, 1'b0, 1'b1, 1'b1, 12'h0EF);
    // R6: carry across slice boundaries
    step("R6", 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
    step("R6", 1'b1, 1'b0, 1'b1, 1'b1, 12'hFFE);
    step("R6", 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
    // R5: all ones, tc high with en_par low, low with en_carry low
    step("R5", 1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
    step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    // R3: wrap to zero
    step("R3", 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
    // R3: full wrap of the whole count
    for (int i = 0; i < (1 << W); i++) begin
      step("R3", 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
    end
    chk_q("R3", '0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic c, l, ep, et;
      logic [W-1:0] d;
      c  = ($urandom % 16) != 0;
      l  = ($urandom % 8) != 0;
      ep = ($urandom % 4) != 0;
      et = ($urandom % 4) != 0;
      d  = (($urandom % 2) == 0) ? (ALL1 - W'($urandom % 4)) : W'($urandom);
      step("R1/R2/R3/R4 random", c, l, ep, et, d);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule